// File: doc/BRIEF.md
# Event Interrupt Controller with Write-One-to-Clear Status

This block gathers four event pulses from a peripheral (data available, status valid, locality change and command ready) and records each in a sticky status register. Software reads that register over a 32-bit register bus and clears bits by writing ones to them. A per-source enable mask and a master enable bit decide which pending events reach the single interrupt line. The line's polarity and its edge or level behaviour are chosen by parameters. A capability word reports which of the four signalling styles was built.

The register bus is a simple request interface. A write takes effect on the clock edge that samples the request. A read returns its data on `bus_rdata` after that same edge, and the value is held until the next read. The block also has an 8-bit vector register that the host programs and reads back. Producing the events is left to the peripheral.

Top module: `evt_irq_ctrl`

## Requirements
- R1: After reset the enable, status and vector registers read as zero and the interrupt line is at its idle level. Addresses that map to no register read as zero.
- R2: The enable register sits at offset 0x08. Bits 0, 1, 2 and 7 are the per-source enables and bit 31 is the master enable. These five bits read back as written and every other bit reads 0.
- R3: The status register sits at offset 0x10. An event pulse sets its status bit whether or not that source is enabled: data available sets bit 0, status valid bit 1, locality change bit 2 and command ready bit 7.
- R4: Writing 1 to a status bit clears it and writing 0 leaves it unchanged. Writing back a value just read from the status register clears every bit that was pending.
- R5: When an event pulse and a clearing write hit the same status bit in the same cycle, the bit stays set.
- R6: While master enable bit 31 is 0, the interrupt line stays idle whatever is pending.
- R7: A pending source whose enable bit is 0 does not drive the line.
- R8: In level mode the line is active from the second clock edge after an enabled bit becomes pending. It stays active while any enabled bit is pending and returns to idle one edge after the last one clears.
- R9: In edge mode the line is active for exactly one cycle when the set of enabled pending bits goes from empty to non-empty. New events arriving while the set is already non-empty give no further pulse.
- R10: The vector register sits at offset 0x0C and is 8 bits wide. Any value from 3 to 15 written to it reads back unchanged, and it holds its value when it is not written.
- R11: The capability register sits at offset 0x14 and is read-only. Bits 0, 1, 2 and 7 read 1. Exactly one of bits 3 (level, active high), 4 (level, active low), 5 (rising edge) or 6 (falling edge) reads 1, matching the build parameters. Bit 8 reports the static burst count parameter.
- R12: With active-low polarity the idle level is 1 and the active level is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| bus_req | input | 1 | Register access request, one cycle per access |
| bus_we | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid after the edge that samples the read |
| evt_data_avail | input | 1 | Event pulse: data available |
| evt_sts_valid | input | 1 | Event pulse: status valid |
| evt_loc_change | input | 1 | Event pulse: locality change |
| evt_cmd_ready | input | 1 | Event pulse: command ready |
| irq_o | output | 1 | Interrupt line |

## Verification
Each result has a fixed due cycle. Read data can be sampled at the first falling edge after the rising edge that took the request. A status or enable change is visible in a read issued one cycle later. The interrupt line moves one rising edge after that, so it is due at the second falling edge after an event pulse or enable write was driven. The scoreboard queues each expected read word when the request is driven and pops it at that falling edge. Interrupt checks are taken at falling edges counted from the stimulus, and a second instance built for active-low edge mode is checked on the same cycles for its one-cycle pulse.

// File: rtl/evt_irq_pkg.sv
package evt_irq_pkg;

  localparam int DATA_W = 32;
  localparam int NSRC   = 4;
  localparam int VEC_W  = 8;

  // status / enable positions of the sources (decoded by software)
  localparam int POS_DAV = 0;
  localparam int POS_STV = 1;
  localparam int POS_LOC = 2;
  localparam int POS_CRD = 7;
  localparam int POS_GLB = 31;

  // capability positions
  localparam int CAP_LVL_HI = 3;
  localparam int CAP_LVL_LO = 4;
  localparam int CAP_RISE   = 5;
  localparam int CAP_FALL   = 6;
  localparam int CAP_BURST  = 8;

  // register byte offsets
  localparam int OFS_ENABLE = 'h08;
  localparam int OFS_VECTOR = 'h0C;
  localparam int OFS_STATUS = 'h10;
  localparam int OFS_CAPS   = 'h14;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_ENABLE,
    SEL_VECTOR,
    SEL_STATUS,
    SEL_CAPS
  } reg_sel_e;

  // source index -> bit position
  function automatic int pos_of(input int src);
    case (src)
      0:       return POS_DAV;
      1:       return POS_STV;
      2:       return POS_LOC;
      default: return POS_CRD;
    endcase
  endfunction

  // bit position -> source index, -1 when no source lives there
  function automatic int src_of(input int bitpos);
    case (bitpos)
      POS_DAV: return 0;
      POS_STV: return 1;
      POS_LOC: return 2;
      POS_CRD: return 3;
      default: return -1;
    endcase
  endfunction

endpackage

// File: rtl/evt_irq_spread.sv
module evt_irq_spread
  import evt_irq_pkg::*;
(
  input  logic [NSRC-1:0]   src_i,
  output logic [DATA_W-1:0] word_o
);

  for (genvar b = 0; b < DATA_W; b++) begin : g_bit
    localparam int S = src_of(b);
    if (S >= 0) begin : g_src
      assign word_o[b] = src_i[S];
    end else begin : g_zero
      assign word_o[b] = 1'b0;
    end
  end

endmodule

// File: rtl/evt_irq_status.sv
module evt_irq_status
  import evt_irq_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] evt_i,
  input  logic [NSRC-1:0] clr_i,
  output logic [NSRC-1:0] stat_o
);

  logic [NSRC-1:0] stat_d;
  logic [NSRC-1:0] stat_q;

  for (genvar g = 0; g < NSRC; g++) begin : g_src
    // a new event outranks a clearing write in the same cycle
    always_comb begin
      stat_d[g] = stat_q[g];
      if (clr_i[g]) stat_d[g] = 1'b0;
      if (evt_i[g]) stat_d[g] = 1'b1;
    end

    AST_EVT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
      evt_i[g] |=> stat_q[g]);  // R3 R5

    AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i[g] && !evt_i[g]) |=> !stat_q[g]);  // R4
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stat_q <= '0;
    else        stat_q <= stat_d;
  end

  assign stat_o = stat_q;

endmodule

// File: rtl/evt_irq_drive.sv
module evt_irq_drive
  import evt_irq_pkg::*;
#(
  parameter bit IRQ_ACT_HIGH = 1'b1,
  parameter bit EDGE_MODE    = 1'b0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] stat_i,
  input  logic [NSRC-1:0] en_src_i,
  input  logic            glb_en_i,
  output logic            irq_o
);

  logic pend;
  logic act_d;
  logic act_q;

  assign pend = glb_en_i & (|(stat_i & en_src_i));

  if (EDGE_MODE) begin : g_edge
    logic prev_q;

    always_comb act_d = pend & ~prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= 1'b0;
      else        prev_q <= pend;
    end

    AST_EDGE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      act_q |=> !act_q);  // R9
  end else begin : g_level
    always_comb act_d = pend;

    AST_LEVEL_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
      pend |=> (irq_o == IRQ_ACT_HIGH));  // R8
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) act_q <= 1'b0;
    else        act_q <= act_d;
  end

  assign irq_o = IRQ_ACT_HIGH ? act_q : ~act_q;

  AST_MASKED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !(|(stat_i & en_src_i)) |=> (irq_o == !IRQ_ACT_HIGH));  // R7

endmodule

// File: rtl/evt_irq_regs.sv
module evt_irq_regs
  import evt_irq_pkg::*;
#(
  parameter int ADDR_W       = 12,
  parameter bit IRQ_ACT_HIGH = 1'b1,
  parameter bit EDGE_MODE    = 1'b0,
  parameter bit BURST_STATIC = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_req,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic [NSRC-1:0]   stat_i,
  output logic [NSRC-1:0]   en_src_o,
  output logic              glb_en_o,
  output logic [NSRC-1:0]   stat_clr_o,
  output logic [DATA_W-1:0] bus_rdata
);

  localparam logic [DATA_W-1:0] MODE_CAPS =
      (DATA_W'(!EDGE_MODE &&  IRQ_ACT_HIGH) << CAP_LVL_HI)
    | (DATA_W'(!EDGE_MODE && !IRQ_ACT_HIGH) << CAP_LVL_LO)
    | (DATA_W'( EDGE_MODE &&  IRQ_ACT_HIGH) << CAP_RISE)
    | (DATA_W'( EDGE_MODE && !IRQ_ACT_HIGH) << CAP_FALL)
    | (DATA_W'(BURST_STATIC) << CAP_BURST);

  reg_sel_e          sel;
  logic              wr_hit;
  logic              rd_hit;
  logic [NSRC-1:0]   wd_src;
  logic [DATA_W-1:0] en_word;
  logic [DATA_W-1:0] stat_word;
  logic [DATA_W-1:0] src_caps;
  logic [DATA_W-1:0] caps_word;

  logic [NSRC-1:0]   en_d,  en_q;
  logic              glb_d, glb_q;
  logic [VEC_W-1:0]  vec_d, vec_q;
  logic [DATA_W-1:0] rd_d,  rd_q;

  logic unused_wd;
  assign unused_wd = ^bus_wdata[DATA_W-2:VEC_W];

  // address decode
  always_comb begin
    sel = SEL_NONE;
    if      (bus_addr == ADDR_W'(OFS_ENABLE)) sel = SEL_ENABLE;
    else if (bus_addr == ADDR_W'(OFS_VECTOR)) sel = SEL_VECTOR;
    else if (bus_addr == ADDR_W'(OFS_STATUS)) sel = SEL_STATUS;
    else if (bus_addr == ADDR_W'(OFS_CAPS))   sel = SEL_CAPS;
  end

  assign wr_hit = bus_req &  bus_we;
  assign rd_hit = bus_req & ~bus_we;

  for (genvar g = 0; g < NSRC; g++) begin : g_wsrc
    localparam int P = pos_of(g);
    assign wd_src[g] = bus_wdata[P];
  end

  evt_irq_spread u_spread_en   (.src_i(en_q),          .word_o(en_word));
  evt_irq_spread u_spread_stat (.src_i(stat_i),        .word_o(stat_word));
  evt_irq_spread u_spread_caps (.src_i({NSRC{1'b1}}),  .word_o(src_caps));

  assign caps_word  = src_caps | MODE_CAPS;
  assign stat_clr_o = (wr_hit && sel == SEL_STATUS) ? wd_src : '0;

  // next state
  always_comb begin
    en_d  = en_q;
    glb_d = glb_q;
    vec_d = vec_q;
    if (wr_hit && sel == SEL_ENABLE) begin
      en_d  = wd_src;
      glb_d = bus_wdata[POS_GLB];
    end
    if (wr_hit && sel == SEL_VECTOR) begin
      vec_d = bus_wdata[VEC_W-1:0];
    end
  end

  always_comb begin
    case (sel)
      SEL_ENABLE: rd_d = en_word | (DATA_W'(glb_q) << POS_GLB);
      SEL_VECTOR: rd_d = DATA_W'(vec_q);
      SEL_STATUS: rd_d = stat_word;
      SEL_CAPS:   rd_d = caps_word;
      default:    rd_d = '0;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= '0;
      glb_q <= 1'b0;
      vec_q <= '0;
      rd_q  <= '0;
    end else begin
      en_q  <= en_d;
      glb_q <= glb_d;
      vec_q <= vec_d;
      if (rd_hit) rd_q <= rd_d;
    end
  end

  assign en_src_o  = en_q;
  assign glb_en_o  = glb_q;
  assign bus_rdata = rd_q;

  AST_VEC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_hit && sel == SEL_VECTOR) |=> $stable(vec_q));  // R10

  AST_GLB_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hit && sel == SEL_ENABLE) |=> (glb_en_o == $past(bus_wdata[POS_GLB])));  // R2

  AST_CAPS_ONE_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_hit && sel == SEL_CAPS) |=> ($countones(bus_rdata[CAP_FALL:CAP_LVL_HI]) == 1));  // R11

endmodule

// File: rtl/evt_irq_ctrl.sv
module evt_irq_ctrl
  import evt_irq_pkg::*;
#(
  parameter int ADDR_W       = 12,
  parameter bit IRQ_ACT_HIGH = 1'b1,
  parameter bit EDGE_MODE    = 1'b0,
  parameter bit BURST_STATIC = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_req,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic              evt_data_avail,
  input  logic              evt_sts_valid,
  input  logic              evt_loc_change,
  input  logic              evt_cmd_ready,
  output logic              irq_o
);

  logic [1:0]      rsync_q;
  logic            rst_int_n;
  logic [NSRC-1:0] evt;
  logic [NSRC-1:0] stat;
  logic [NSRC-1:0] stat_clr;
  logic [NSRC-1:0] en_src;
  logic            glb_en;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= '0;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_int_n = rsync_q[1];

  assign evt = {evt_cmd_ready, evt_loc_change, evt_sts_valid, evt_data_avail};

  evt_irq_regs #(
    .ADDR_W       (ADDR_W),
    .IRQ_ACT_HIGH (IRQ_ACT_HIGH),
    .EDGE_MODE    (EDGE_MODE),
    .BURST_STATIC (BURST_STATIC)
  ) u_regs (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .bus_req    (bus_req),
    .bus_we     (bus_we),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .stat_i     (stat),
    .en_src_o   (en_src),
    .glb_en_o   (glb_en),
    .stat_clr_o (stat_clr),
    .bus_rdata  (bus_rdata)
  );

  evt_irq_status u_status (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .evt_i  (evt),
    .clr_i  (stat_clr),
    .stat_o (stat)
  );

  evt_irq_drive #(
    .IRQ_ACT_HIGH (IRQ_ACT_HIGH),
    .EDGE_MODE    (EDGE_MODE)
  ) u_drive (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .stat_i   (stat),
    .en_src_i (en_src),
    .glb_en_i (glb_en),
    .irq_o    (irq_o)
  );

  AST_GLOBAL_GATE: assert property (@(posedge clk) disable iff (!rst_int_n)
    !glb_en |=> (irq_o == !IRQ_ACT_HIGH));  // R6 R12

endmodule

// File: tb/evt_irq_ctrl_tb.sv
module evt_irq_ctrl_tb;

  localparam logic [11:0] A_EN   = 12'h008;
  localparam logic [11:0] A_VEC  = 12'h00C;
  localparam logic [11:0] A_STAT = 12'h010;
  localparam logic [11:0] A_CAPS = 12'h014;

  typedef struct {
    logic [31:0] exp;
    bit          alt;
    string       tag;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_req = 1'b0;
  logic        bus_we = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [3:0]  evt = '0;
  logic [31:0] rdata_a, rdata_b;
  logic        irq_a, irq_b;
  logic        rd_seen = 1'b0;

  int   n_chk = 0;
  int   n_fail = 0;
  exp_t sbq[$];
  exp_t cur;

  always #2.5 clk = ~clk;  // 200 MHz

  // level mode, active high
  evt_irq_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(rdata_a),
    .evt_data_avail(evt[0]), .evt_sts_valid(evt[1]),
    .evt_loc_change(evt[2]), .evt_cmd_ready(evt[3]), .irq_o(irq_a)
  );

  // edge mode, active low, no static burst count
  evt_irq_ctrl #(.IRQ_ACT_HIGH(1'b0), .EDGE_MODE(1'b1), .BURST_STATIC(1'b0)) u_dut_alt (
    .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(rdata_b),
    .evt_data_avail(evt[0]), .evt_sts_valid(evt[1]),
    .evt_loc_change(evt[2]), .evt_cmd_ready(evt[3]), .irq_o(irq_b)
  );

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic finish_up();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_req = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_req = 1'b0; bus_we = 1'b0;
  endtask

  // driver: push the expected word, issue the read
  task automatic rd(input logic [11:0] a, input logic [31:0] e, input bit alt, input string tag);
    exp_t it;
    it.exp = e; it.alt = alt; it.tag = tag;
    @(negedge clk);
    sbq.push_back(it);
    bus_req = 1'b1; bus_we = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_req = 1'b0;
  endtask

  task automatic pulse(input logic [3:0] m);
    @(negedge clk);
    evt = m;
    @(negedge clk);
    evt = '0;
  endtask

  // monitor: read data is due at the falling edge after the sampling edge
  always @(posedge clk) rd_seen <= bus_req && !bus_we;

  always @(negedge clk) begin
    if (rd_seen) begin
      if (sbq.size() == 0) begin
        n_chk++; n_fail++;
        $display("FAIL scoreboard: read data with no expected item");
      end else begin
        cur = sbq.pop_front();
        check(cur.alt ? rdata_b : rdata_a, cur.exp, cur.tag);
      end
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: run did not complete");
    finish_up();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R1 reset state
    check(32'(irq_a), 32'h0, "R1 idle line level mode");
    check(32'(irq_b), 32'h1, "R1 R12 idle line active-low");
    rd(A_EN,   32'h0, 0, "R1 enable reset");
    rd(A_STAT, 32'h0, 0, "R1 status reset");
    rd(A_VEC,  32'h0, 0, "R1 vector reset");
    rd(12'h020, 32'h0, 0, "R1 unmapped reads zero");

    // R11 capabilities, read-only
    rd(A_CAPS, 32'h0000018F, 0, "R11 caps level high static burst");
    rd(A_CAPS, 32'h000000C7, 1, "R11 caps falling edge");
    wr(A_CAPS, 32'hFFFFFFFF);
    rd(A_CAPS, 32'h0000018F, 0, "R11 caps ignore write");

    // R2 enable register
    wr(A_EN, 32'hFFFFFFFF);
    rd(A_EN, 32'h80000087, 0, "R2 enable writable bits");
    wr(A_EN, 32'h00000000);
    rd(A_EN, 32'h00000000, 0, "R2 enable cleared");

    // R3 events latch while disabled
    pulse(4'b1111);
    @(negedge clk);
    check(32'(irq_a), 32'h0, "R7 disabled sources quiet");
    rd(A_STAT, 32'h00000087, 0, "R3 status positions");

    // R4 write-one-to-clear
    wr(A_STAT, 32'h00000001);
    rd(A_STAT, 32'h00000086, 0, "R4 single bit clear");
    wr(A_STAT, 32'h00000000);
    rd(A_STAT, 32'h00000086, 0, "R4 zero write keeps bits");
    wr(A_STAT, 32'h00000086);
    rd(A_STAT, 32'h00000000, 0, "R4 write-back clears all");

    // R6 master enable gating
    wr(A_EN, 32'h00000087);
    pulse(4'b0001);
    @(negedge clk);
    check(32'(irq_a), 32'h0, "R6 master off level");
    check(32'(irq_b), 32'h1, "R6 master off edge");

    // R8 R9 R12 turning master on with data pending
    wr(A_EN, 32'h80000087);
    check(32'(irq_a), 32'h0, "R8 not yet active");
    @(negedge clk);
    check(32'(irq_a), 32'h1, "R8 level active");
    check(32'(irq_b), 32'h0, "R9 R12 edge pulse low");
    @(negedge clk);
    check(32'(irq_a), 32'h1, "R8 level held");
    check(32'(irq_b), 32'h1, "R9 pulse lasts one cycle");

    // R9 no new pulse while pending set stays non-empty
    pulse(4'b0010);
    check(32'(irq_b), 32'h1, "R9 no repeat pulse a");
    @(negedge clk);
    check(32'(irq_b), 32'h1, "R9 no repeat pulse b");

    // R8 line drops after clear
    wr(A_STAT, 32'h00000003);
    @(negedge clk);
    check(32'(irq_a), 32'h0, "R8 level drops after clear");

    // R7 per-source enable
    wr(A_EN, 32'h80000001);
    pulse(4'b0100);
    @(negedge clk);
    check(32'(irq_a), 32'h0, "R7 masked source");
    check(32'(irq_b), 32'h1, "R7 masked source edge");
    rd(A_STAT, 32'h00000004, 0, "R3 locality bit 2");
    wr(A_STAT, 32'h00000004);
    wr(A_EN, 32'h80000080);
    pulse(4'b1000);
    @(negedge clk);
    check(32'(irq_a), 32'h1, "R7 command ready enabled");
    wr(A_STAT, 32'h00000080);
    @(negedge clk);
    check(32'(irq_a), 32'h0, "R8 idle after command ready clear");

    // R5 event beats a same-cycle clear
    @(negedge clk);
    evt = 4'b0001;
    bus_req = 1'b1; bus_we = 1'b1; bus_addr = A_STAT; bus_wdata = 32'h00000001;
    @(negedge clk);
    evt = '0; bus_req = 1'b0; bus_we = 1'b0;
    rd(A_STAT, 32'h00000001, 0, "R5 set wins over clear");
    wr(A_STAT, 32'h00000001);
    rd(A_STAT, 32'h00000000, 0, "R4 cleared after R5");

    // R10 vector register
    for (int v = 3; v <= 15; v++) begin
      wr(A_VEC, 32'(v));
      rd(A_VEC, 32'(v), 0, $sformatf("R10 vector %0d", v));
    end
    rd(A_VEC, 32'h0000000F, 0, "R10 vector held");

    repeat (3) @(negedge clk);
    check(32'(sbq.size()), 32'h0, "scoreboard drained");
    finish_up();
  end

endmodule